// File: doc/BRIEF.md
# Two-Sided Byte Mailbox with Write Interrupts

This block is a small register file shared by two independent agents: a host port and a management-controller port. Each port has a simple synchronous register interface. A write strobe, an address and a write byte update state on the rising clock edge. The addressed register appears on a registered read-data output one cycle after the address is presented. Sixteen byte-wide data registers can be read and written from both ports. The two agents use them to pass messages to each other.

Each side owns a bank of configuration registers. These are a control byte with a global interrupt enable and a software doorbell, a 16-bit write-enable vector, a 16-bit mask vector, and a 16-bit pending vector. When the peer writes data register i and this side's enable bit i is set, pending bit i is raised. A side's interrupt output is driven while its global enable is set and at least one pending source is unmasked or its doorbell is pending. Software clears pending bits by writing ones to them.

When both ports write the same data register in one cycle, the controller's byte is stored. Both writes still count as events for their respective peers.

Top module: `xside_mailbox`

## Requirements
- R1: After reset, every data, enable, mask, pending and control bit reads 0, and both interrupt outputs are low.
- R2: A byte written to a data register (address 0..15) by either port can be read back from both ports. Read data is registered and appears the cycle after the address is presented.
- R3: If both ports write the same data register in the same cycle, the controller port's byte is stored.
- R4: A peer write to data register i sets this side's pending bit i only when this side's enable bit i is 1. Pending bits 7:0 sit at address 17 and bits 15:8 at address 18. Enable bits use addresses 19 and 20 in the same arrangement.
- R5: On a same-register collision, both write events are recorded: the host gets a pending bit for the controller's write and the controller gets one for the host's write.
- R6: A side's interrupt output equals control bit 0 (global enable) AND (any pending bit whose mask bit is 0, OR the doorbell-pending bit). Mask bits use addresses 21 and 22, and a mask bit of 1 blocks its source.
- R7: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle as a clear leaves the bit set.
- R8: The control register sits at address 16. Writing 1 to its bit 1 sets the peer's doorbell-pending bit, which reads as control bit 2 on the peer side. Bit 1 itself always reads 0. Writing 1 to bit 2 clears the own doorbell-pending bit.
- R9: A port's own writes to data registers never set that same port's pending bits.
- R10: Addresses 23..31 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 5 | Host register address |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte, registered |
| h_irq | output | 1 | Interrupt toward the host |
| c_we | input | 1 | Controller write strobe |
| c_addr | input | 5 | Controller register address |
| c_wdata | input | 8 | Controller write byte |
| c_rdata | output | 8 | Controller read byte, registered |
| c_irq | output | 1 | Interrupt toward the controller |

## Verification
The hardest cases to reach are the ones that need two ports acting in the same clock edge. The first is a collision on one data register, where the stored byte and both pending records must be checked. The second is a pending bit being cleared by its owner in the very cycle the peer raises it again. The bench has a dual-port write task that drives both strobes on the same falling edge, so both requests commit together. Every result is then read back through the normal read path and compared against queued expectations.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int NREG  = 16;
    localparam int DW    = 8;
    localparam int IW    = $clog2(NREG);
    localparam int NBANK = NREG / DW;
    localparam int NADDR = NREG + 1 + 3 * NBANK;
    localparam int AW    = $clog2(NADDR);

    localparam int OFF_CTRL = NREG;
    localparam int OFF_PEND = NREG + 1;
    localparam int OFF_EN   = OFF_PEND + NBANK;
    localparam int OFF_MSK  = OFF_EN + NBANK;

    localparam int CB_GEN  = 0;
    localparam int CB_TRIG = 1;
    localparam int CB_SWP  = 2;

    typedef enum logic [2:0] {
        SEL_DATA, SEL_CTRL, SEL_PEND, SEL_EN, SEL_MSK, SEL_NONE
    } sel_e;

    typedef struct packed {
        sel_e          sel;
        logic [IW-1:0] idx;
    } dec_t;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } wr_t;

    typedef struct packed {
        logic            gen;
        logic            swp;
        logic [NREG-1:0] en;
        logic [NREG-1:0] msk;
        logic [NREG-1:0] pend;
    } side_t;

    function automatic dec_t decode(input logic [AW-1:0] a);
        dec_t d;
        int   ai;
        ai    = int'(a);
        d.sel = SEL_NONE;
        d.idx = '0;
        if (ai < NREG) begin
            d.sel = SEL_DATA;
            d.idx = IW'(ai);
        end else if (ai == OFF_CTRL) begin
            d.sel = SEL_CTRL;
        end else if (ai >= OFF_PEND && ai < OFF_EN) begin
            d.sel = SEL_PEND;
            d.idx = IW'(ai - OFF_PEND);
        end else if (ai >= OFF_EN && ai < OFF_MSK) begin
            d.sel = SEL_EN;
            d.idx = IW'(ai - OFF_EN);
        end else if (ai >= OFF_MSK && ai < OFF_MSK + NBANK) begin
            d.sel = SEL_MSK;
            d.idx = IW'(ai - OFF_MSK);
        end
        return d;
    endfunction
endpackage

// File: rtl/mbx_data_file.sv
module mbx_data_file
    import mbx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wr_t                h_req,
    input  wr_t                c_req,
    output logic [NREG*DW-1:0] data_q,
    output logic [NREG-1:0]    h_hit,
    output logic [NREG-1:0]    c_hit
);
    dec_t h_dec, c_dec;

    always_comb begin
        h_dec = decode(h_req.addr);
        c_dec = decode(c_req.addr);
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_comb begin
            h_hit[i] = h_req.we && h_dec.sel == SEL_DATA && int'(h_dec.idx) == i;
            c_hit[i] = c_req.we && c_dec.sel == SEL_DATA && int'(c_dec.idx) == i;
        end

        // controller port has priority on a same-cycle collision
        always_ff @(posedge clk) begin
            if (rst)
                data_q[i*DW +: DW] <= '0;
            else if (c_hit[i])
                data_q[i*DW +: DW] <= c_req.wdata;
            else if (h_hit[i])
                data_q[i*DW +: DW] <= h_req.wdata;
        end
    end
endmodule

// File: rtl/mbx_side_regs.sv
module mbx_side_regs
    import mbx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  wr_t             own_req,
    input  logic [NREG-1:0] peer_hit,
    input  logic            peer_trig,
    output logic            trig_out,
    output side_t           st,
    output logic            irq
);
    dec_t            dec;
    logic            ctrl_wr;
    logic [NREG-1:0] clr_vec;
    logic [NREG-1:0] en_q, msk_q, pend_q;
    logic            gen_q, swp_q;

    always_comb begin
        dec      = decode(own_req.addr);
        ctrl_wr  = own_req.we && dec.sel == SEL_CTRL;
        trig_out = ctrl_wr && own_req.wdata[CB_TRIG];
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit_en, hit_msk, hit_pend;
        always_comb begin
            hit_en   = own_req.we && dec.sel == SEL_EN   && int'(dec.idx) == b;
            hit_msk  = own_req.we && dec.sel == SEL_MSK  && int'(dec.idx) == b;
            hit_pend = own_req.we && dec.sel == SEL_PEND && int'(dec.idx) == b;
            clr_vec[b*DW +: DW] = hit_pend ? own_req.wdata : '0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[b*DW +: DW]  <= '0;
                msk_q[b*DW +: DW] <= '0;
            end else begin
                if (hit_en)  en_q[b*DW +: DW]  <= own_req.wdata;
                if (hit_msk) msk_q[b*DW +: DW] <= own_req.wdata;
            end
        end
    end

    // new events take precedence over a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            gen_q  <= 1'b0;
            swp_q  <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | (peer_hit & en_q);
            if (ctrl_wr) gen_q <= own_req.wdata[CB_GEN];
            swp_q  <= (swp_q & ~(ctrl_wr && own_req.wdata[CB_SWP])) | peer_trig;
        end
    end

    always_comb begin
        st.gen  = gen_q;
        st.swp  = swp_q;
        st.en   = en_q;
        st.msk  = msk_q;
        st.pend = pend_q;
        irq     = gen_q && ((|(pend_q & ~msk_q)) || swp_q);
    end
endmodule

// File: rtl/mbx_read_port.sv
module mbx_read_port
    import mbx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      addr,
    input  logic [NREG*DW-1:0] data_q,
    input  side_t              st,
    output logic [DW-1:0]      rdata
);
    dec_t          dec;
    logic [DW-1:0] rd_nxt;

    always_comb begin
        dec    = decode(addr);
        rd_nxt = '0;
        unique case (dec.sel)
            SEL_DATA: rd_nxt = data_q[int'(dec.idx)*DW +: DW];
            SEL_CTRL: begin
                rd_nxt[CB_GEN] = st.gen;
                rd_nxt[CB_SWP] = st.swp;
            end
            SEL_PEND: rd_nxt = st.pend[int'(dec.idx)*DW +: DW];
            SEL_EN:   rd_nxt = st.en[int'(dec.idx)*DW +: DW];
            SEL_MSK:  rd_nxt = st.msk[int'(dec.idx)*DW +: DW];
            default:  rd_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_nxt;
    end
endmodule

// File: rtl/xside_mailbox.sv
module xside_mailbox
    import mbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    output logic          h_irq,
    input  logic          c_we,
    input  logic [AW-1:0] c_addr,
    input  logic [DW-1:0] c_wdata,
    output logic [DW-1:0] c_rdata,
    output logic          c_irq
);
    wr_t                h_req, c_req;
    logic [NREG*DW-1:0] data_q;
    logic [NREG-1:0]    h_hit, c_hit;
    logic               h_trig, c_trig;
    side_t              h_st, c_st;
    logic               h_gen, h_swp;
    logic [NREG-1:0]    c_en, c_pend;

    always_comb begin
        h_req  = '{we: h_we, addr: h_addr, wdata: h_wdata};
        c_req  = '{we: c_we, addr: c_addr, wdata: c_wdata};
        h_gen  = h_st.gen;
        h_swp  = h_st.swp;
        c_en   = c_st.en;
        c_pend = c_st.pend;
    end

    mbx_data_file u_data (
        .clk(clk), .rst(rst), .h_req(h_req), .c_req(c_req),
        .data_q(data_q), .h_hit(h_hit), .c_hit(c_hit)
    );

    // host side is raised by controller writes, and vice versa
    mbx_side_regs u_hside (
        .clk(clk), .rst(rst), .own_req(h_req), .peer_hit(c_hit),
        .peer_trig(c_trig), .trig_out(h_trig), .st(h_st), .irq(h_irq)
    );

    mbx_side_regs u_cside (
        .clk(clk), .rst(rst), .own_req(c_req), .peer_hit(h_hit),
        .peer_trig(h_trig), .trig_out(c_trig), .st(c_st), .irq(c_irq)
    );

    mbx_read_port u_hrd (
        .clk(clk), .rst(rst), .addr(h_addr), .data_q(data_q),
        .st(h_st), .rdata(h_rdata)
    );

    mbx_read_port u_crd (
        .clk(clk), .rst(rst), .addr(c_addr), .data_q(data_q),
        .st(c_st), .rdata(c_rdata)
    );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import mbx_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               h_we,
    input logic [AW-1:0]      h_addr,
    input logic [DW-1:0]      h_wdata,
    input logic               c_we,
    input logic [AW-1:0]      c_addr,
    input logic [DW-1:0]      c_wdata,
    input logic               h_irq,
    input logic               c_irq,
    input logic [NREG*DW-1:0] data_q,
    input logic               h_gen,
    input logic               h_swp,
    input logic [NREG-1:0]    c_en,
    input logic [NREG-1:0]    c_pend
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        rst |=> (!h_irq && !c_irq));

    assert_ctrl_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (h_we && c_we && h_addr == c_addr && int'(c_addr) < NREG)
        |=> data_q[int'($past(c_addr[IW-1:0]))*DW +: DW] == $past(c_wdata));

    assert_pend_raised_R4: assert property (@(posedge clk) disable iff (rst)
        (h_we && int'(h_addr) < NREG && c_en[h_addr[IW-1:0]])
        |=> c_pend[$past(h_addr[IW-1:0])]);

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
        h_irq |-> h_gen);

    assert_doorbell_R8: assert property (@(posedge clk) disable iff (rst)
        (c_we && int'(c_addr) == OFF_CTRL && c_wdata[CB_TRIG]) |=> h_swp);
endmodule

bind xside_mailbox mbx_checker u_chk (
    .clk(clk), .rst(rst),
    .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
    .h_irq(h_irq), .c_irq(c_irq), .data_q(data_q),
    .h_gen(h_gen), .h_swp(h_swp), .c_en(c_en), .c_pend(c_pend)
);

// File: tb/xside_mailbox_test.sv
module xside_mailbox_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       h_we = 1'b0, c_we = 1'b0;
    logic [4:0] h_addr = '0, c_addr = '0;
    logic [7:0] h_wdata = '0, c_wdata = '0;
    logic [7:0] h_rdata, c_rdata;
    logic       h_irq, c_irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        bit         port;   // 0 host, 1 controller
        logic [7:0] exp;
        int         due;
        string      tag;
    } item_t;
    item_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    xside_mailbox uut (
        .clk(clk), .rst(rst),
        .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
        .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata), .c_irq(c_irq)
    );

    // monitor: compares read data when it is due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [7:0] act;
            it  = q.pop_front();
            act = it.port ? c_rdata : h_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: read got %02h expected %02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic rd(input bit port, input int a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        h_we = 1'b0; c_we = 1'b0;
        if (port) c_addr = 5'(a); else h_addr = 5'(a);
        q.push_back('{port: port, exp: exp, due: cyc + 1, tag: tag});
        @(negedge clk);
    endtask

    task automatic wr(input bit port, input int a, input logic [7:0] d);
        @(negedge clk);
        if (port) begin c_we = 1'b1; c_addr = 5'(a); c_wdata = d; end
        else      begin h_we = 1'b1; h_addr = 5'(a); h_wdata = d; end
        @(negedge clk);
        h_we = 1'b0; c_we = 1'b0;
    endtask

    task automatic wr2(input int ha, input logic [7:0] hd, input int ca, input logic [7:0] cd);
        @(negedge clk);
        h_we = 1'b1; h_addr = 5'(ha); h_wdata = hd;
        c_we = 1'b1; c_addr = 5'(ca); c_wdata = cd;
        @(negedge clk);
        h_we = 1'b0; c_we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        chk(h_irq, 1'b0, "R1 h_irq");
        chk(c_irq, 1'b0, "R1 c_irq");
        rd(0, 0, 8'h00, "R1 data0");
        rd(1, 16, 8'h00, "R1 ctrl");
        rd(1, 17, 8'h00, "R1 pend");
        rd(0, 19, 8'h00, "R1 en");

        // R2 both directions, no enables: no pending anywhere (R4, R9)
        wr(0, 3, 8'hA5);
        rd(1, 3, 8'hA5, "R2 host->ctrl");
        rd(0, 3, 8'hA5, "R2 host own");
        rd(1, 17, 8'h00, "R4 disabled no pend");
        rd(0, 17, 8'h00, "R9 own no pend");
        for (int i = 0; i < 8; i++) wr(1, i + 4, 8'h10 + 8'(i));
        for (int i = 0; i < 8; i++) rd(0, i + 4, 8'h10 + 8'(i), "R2 ctrl->host");
        rd(0, 17, 8'h00, "R4 host en clear");
        rd(0, 18, 8'h00, "R4 host en clear hi");

        // R4/R6 controller enables reg 3 and reg 15, global on
        wr(1, 19, 8'h08);
        wr(1, 20, 8'h80);
        wr(1, 16, 8'h01);
        chk(c_irq, 1'b0, "R6 nothing pending");
        wr(0, 3, 8'h3C);
        chk(c_irq, 1'b1, "R6 irq raised");
        chk(h_irq, 1'b0, "R9 host quiet");
        rd(1, 17, 8'h08, "R4 pend bit3");
        rd(1, 20, 8'h80, "R4 en readback");

        // R6 mask and global enable gating
        wr(1, 21, 8'h08);
        chk(c_irq, 1'b0, "R6 masked");
        rd(1, 21, 8'h08, "R6 mask readback");
        wr(1, 21, 8'h00);
        chk(c_irq, 1'b1, "R6 unmasked");
        wr(1, 16, 8'h00);
        chk(c_irq, 1'b0, "R6 global off");
        wr(1, 16, 8'h01);
        chk(c_irq, 1'b1, "R6 global on");

        // R7 clear semantics
        wr(1, 17, 8'h00);
        rd(1, 17, 8'h08, "R7 zero keeps");
        wr(1, 17, 8'h08);
        rd(1, 17, 8'h00, "R7 one clears");
        chk(c_irq, 1'b0, "R7 irq dropped");

        // R3/R5 collision on reg 15
        wr(0, 20, 8'h80);
        wr(0, 16, 8'h01);
        wr2(15, 8'h11, 15, 8'h22);
        rd(0, 15, 8'h22, "R3 ctrl wins");
        rd(1, 15, 8'h22, "R3 ctrl wins c");
        rd(1, 18, 8'h80, "R5 ctrl pend");
        rd(0, 18, 8'h80, "R5 host pend");
        chk(h_irq, 1'b1, "R5 h_irq");
        chk(c_irq, 1'b1, "R5 c_irq");

        // R7 set wins over simultaneous clear
        wr2(15, 8'h44, 18, 8'h80);
        rd(1, 18, 8'h80, "R7 set wins");
        rd(1, 15, 8'h44, "R2 host write lands");

        // R8 doorbell
        wr2(18, 8'h80, 18, 8'h80);
        chk(h_irq, 1'b0, "R7 h cleared");
        chk(c_irq, 1'b0, "R7 c cleared");
        wr(0, 16, 8'h03);
        chk(c_irq, 1'b1, "R8 doorbell irq");
        rd(1, 16, 8'h05, "R8 peer sees swp");
        rd(0, 16, 8'h01, "R8 trig bit reads 0");
        wr(1, 16, 8'h05);
        rd(1, 16, 8'h01, "R8 swp cleared");
        chk(c_irq, 1'b0, "R8 irq gone");

        // R10 unmapped addresses
        wr(0, 31, 8'hFF);
        wr(1, 23, 8'hFF);
        rd(0, 31, 8'h00, "R10 read zero");
        rd(1, 23, 8'h00, "R10 read zero c");
        rd(0, 17, 8'h00, "R10 pend untouched");
        rd(1, 21, 8'h00, "R10 mask untouched");
        chk(h_irq, 1'b0, "R10 h_irq");
        chk(c_irq, 1'b0, "R10 c_irq");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule